// File: doc/BRIEF.md
# Radix-4 Booth Carry-Save Sequential Multiplier

This block multiplies two signed W-bit two's-complement operands, a multiplicand and a multiplier, and returns their full 2W-bit signed product. Each iteration handles two multiplier bits. A Booth digit selector turns an overlapping three-bit window of the multiplier into one of the multiples 0, ±a or ±2a. A row of carry-save adders adds that multiple into a running sum that is kept as two separate vectors, a sum vector and a carry vector. The two lowest bits of that running sum become final in each iteration and are shifted out into the low half of the product.

An operation starts when `start` is sampled high while the block is idle. The operands are captured in that same cycle. The iterations then run for W/2 cycles, and one closing cycle joins the redundant upper half through a carry-propagate adder. `done` then pulses for one cycle, and `product` holds the result until the next operation finishes. A negative multiple is formed as the bitwise complement of the selected value, with a +1 injected into the empty lowest slot of the shifted carry vector. Each multiple also has its sign bit flipped, so the accumulated value never goes negative. The constant that this flip adds is removed in the closing cycle.

Top module: `booth_csa_mul`

## Requirements
- R1: When `done` is high, `product` equals the signed product of the captured multiplicand and multiplier, as a 2W-bit two's-complement value.
- R2: `done` is high for exactly one cycle. The first clock edge at which it is seen high is the (W/2+1)th edge after the edge that accepted `start`.
- R3: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high. A `start` that arrives while `busy` is high changes neither the result nor the timing, and it launches no further operation.
- R4: The corner cases give exact results. The most negative value times itself gives +2^(2W-2). A zero operand gives 0. A multiplier of -1 negates the multiplicand. A multiplier of +1 returns the multiplicand sign-extended.
- R5: Each multiplier window (bit 2j+1, bit 2j, bit 2j-1), with bit -1 taken as 0, selects a digit. Windows 000 and 111 give 0, 001 and 010 give +a, 011 gives +2a, 100 gives -2a, and 101 and 110 give -a. A digit is never both negative and zero.
- R6: No carry out of the top bit of the carry-save accumulator is ever lost during the iterations, even for the extreme operand values.
- R7: Between two `done` pulses, `product` stays unchanged. With no accepted `start`, `done` stays low.
- R8: After reset, `done` is 0, `busy` is 0 and `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only when idle |
| mcand | input | W | Signed multiplicand, captured on acceptance |
| mplier | input | W | Signed multiplier, captured on acceptance |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `product` is valid |
| product | output | 2W | Signed product, held until the next `done` |

## Verification
The bench runs a W=6 instance through every pair of operands. This reaches every combination of Booth windows with every multiplicand, so it catches a wrong digit mapping, a wrong complement or a wrong injected carry. It also catches a faulty final bias removal, because that error shows only in the upper half. Named runs cover the extremes: the most negative value squared, the zero, ±1 and alternating-bit multipliers, and any multiplicand with multipliers 011111 and 100000. These separate sign-extension and overflow faults from plain selection faults. A `start` pulsed in the middle of an operation, followed by idle cycles, shows whether the busy guard and the product hold are working. A latency count on every operation exposes an iteration counter that is off by one.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ITER  = 2'd1,
        ST_FINAL = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_digit_t;

    // Window is {upper, middle, lower} multiplier bits.
    function automatic booth_digit_t booth_recode(input logic [2:0] win);
        booth_digit_t dg;
        dg = '0;
        case (win)
            3'b001, 3'b010: dg.one = 1'b1;
            3'b011:         dg.two = 1'b1;
            3'b100: begin
                dg.two = 1'b1;
                dg.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                dg.one = 1'b1;
                dg.neg = 1'b1;
            end
            default:        dg = '0;
        endcase
        return dg;
    endfunction

endpackage

// File: rtl/booth_sel.sv
module booth_sel
    import booth_mul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mcand,
    input  logic [2:0]   win,
    output logic [W+1:0] mult,
    output logic         inj
);
    localparam int MW = W + 2;

    booth_digit_t dg;
    logic [MW-1:0] single_v;
    logic [MW-1:0] double_v;
    logic [MW-1:0] mag;
    logic [MW-1:0] raw;

    assign dg       = booth_recode(win);
    assign single_v = {{2{mcand[W-1]}}, mcand};
    assign double_v = {mcand[W-1], mcand, 1'b0};

    genvar i;
    generate
        for (i = 0; i < MW; i++) begin : g_bit
            assign mag[i] = (dg.one & single_v[i]) | (dg.two & double_v[i]);
            assign raw[i] = mag[i] ^ dg.neg;
        end
    endgenerate

    // Sign bit flipped: every multiple becomes non-negative with a fixed offset.
    assign mult = {~raw[MW-1], raw[MW-2:0]};
    assign inj  = dg.neg;

    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dg.one, dg.two}));

    p_neg_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dg.neg |-> (dg.one | dg.two));

endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic [N-1:0] z,
    output logic [N-1:0] s,
    output logic [N-1:0] c
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_fa
            assign s[i] = x[i] ^ y[i] ^ z[i];
            assign c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
        end
    endgenerate
endmodule

// File: rtl/booth_resolve.sv
module booth_resolve #(
    parameter int W = 16
) (
    input  logic [W-1:0] s_hi,
    input  logic [W-1:0] c_hi,
    input  logic         cy,
    output logic [W-1:0] hi
);
    // Offset left by the flipped sign bits, seen from the upper half:
    // ones at odd positions. Its complement (ones at even positions) plus one
    // subtracts it.
    logic [W-1:0] offs_inv;
    logic [W-1:0] rs;
    logic [W-1:0] rc;
    logic [W-1:0] rc_sh;
    logic         unused_top;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_k
            assign offs_inv[i] = ((i % 2) == 0) ? 1'b1 : 1'b0;
        end
    endgenerate

    csa_row #(.N(W)) u_fix (
        .x (s_hi),
        .y (c_hi),
        .z (offs_inv),
        .s (rs),
        .c (rc)
    );

    assign rc_sh      = {rc[W-2:0], 1'b1};
    assign unused_top = rc[W-1];
    assign hi         = rs + rc_sh + {{(W-1){1'b0}}, cy};

endmodule

// File: rtl/booth_csa_mul.sv
module booth_csa_mul
    import booth_mul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int NDIG = W / 2;
    localparam int AW   = W + 3;
    localparam int CNTW = $clog2(NDIG + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(NDIG - 1);

    typedef struct packed {
        mul_state_e     st;
        logic [W-1:0]   a;
        logic [W-1:0]   x;
        logic           xprev;
        logic [AW-1:0]  s;
        logic [AW-1:0]  c;
        logic           cy;
        logic [W-1:0]   lo;
        logic [CNTW-1:0] cnt;
        logic [2*W-1:0] prod;
        logic           done;
    } mul_regs_t;

    mul_regs_t q_q, q_d;

    logic [W+1:0]  mult;
    logic          inj;
    logic [AW-1:0] csum;
    logic [AW-1:0] ccar;
    logic [AW-1:0] ccar_sh;
    logic [2:0]    low3;
    logic [W-1:0]  hi;

    booth_sel #(.W(W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .mcand (q_q.a),
        .win   ({q_q.x[1], q_q.x[0], q_q.xprev}),
        .mult  (mult),
        .inj   (inj)
    );

    csa_row #(.N(AW)) u_acc (
        .x (q_q.s),
        .y (q_q.c),
        .z ({1'b0, mult}),
        .s (csum),
        .c (ccar)
    );

    // Negative-digit +1 goes into the empty lowest slot of the shifted carries.
    assign ccar_sh = {ccar[AW-2:0], inj};
    assign low3    = {1'b0, csum[1:0]} + {1'b0, ccar_sh[1:0]} + {2'b00, q_q.cy};

    booth_resolve #(.W(W)) u_res (
        .s_hi (q_q.s[W-1:0]),
        .c_hi (q_q.c[W-1:0]),
        .cy   (q_q.cy),
        .hi   (hi)
    );

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        case (q_q.st)
            ST_IDLE: begin
                if (start) begin
                    q_d.st    = ST_ITER;
                    q_d.a     = mcand;
                    q_d.x     = mplier;
                    q_d.xprev = 1'b0;
                    q_d.s     = '0;
                    q_d.c     = '0;
                    q_d.cy    = 1'b0;
                    q_d.lo    = '0;
                    q_d.cnt   = '0;
                end
            end
            ST_ITER: begin
                q_d.s     = {2'b00, csum[AW-1:2]};
                q_d.c     = {2'b00, ccar_sh[AW-1:2]};
                q_d.cy    = low3[2];
                q_d.lo    = {low3[1:0], q_q.lo[W-1:2]};
                q_d.xprev = q_q.x[1];
                q_d.x     = {{2{q_q.x[W-1]}}, q_q.x[W-1:2]};
                q_d.cnt   = q_q.cnt + 1'b1;
                if (q_q.cnt == LAST) begin
                    q_d.st = ST_FINAL;
                end
            end
            ST_FINAL: begin
                q_d.prod = {hi, q_q.lo};
                q_d.done = 1'b1;
                q_d.st   = ST_IDLE;
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign busy    = (q_q.st != ST_IDLE);
    assign done    = q_q.done;
    assign product = q_q.prod;

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_ITER) |-> !ccar[AW-1]);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_final_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_FINAL) |=> done);

    p_busy_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q_q.a));

    p_product_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !q_d.done |=> $stable(product));

endmodule

// File: tb/booth_csa_mul_test.sv
module booth_csa_mul_test;
    localparam int W       = 6;
    localparam int CLK_PER = 10;
    localparam int LAT     = W / 2 + 1;
    localparam int VMIN    = -(1 << (W - 1));
    localparam int VMAX    = (1 << (W - 1)) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   mcand = '0;
    logic [W-1:0]   mplier = '0;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int checks = 0;
    int fails  = 0;

    booth_csa_mul #(.W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input int a, input int x);
        return (2 * W)'(a * x);
    endfunction

    // Launch, wait for done, return product and edges after acceptance.
    task automatic run_op(input int a, input int x, output logic [2*W-1:0] got, output int lat);
        @(negedge clk);
        start  = 1'b1;
        mcand  = W'(a);
        mplier = W'(x);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        got = product;
    endtask

    task automatic op_check(input string req, input int a, input int x);
        logic [2*W-1:0] got;
        int lat;
        run_op(a, x, got, lat);
        check(req, 64'(got), 64'(ref_mul(a, x)));
        check("R2 latency", 64'(lat), 64'(LAT));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [2*W-1:0] got;
        logic [2*W-1:0] held;
        int lat;

        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 done", 64'(done), 64'(0));
        check("R8 busy", 64'(busy), 64'(0));
        check("R8 product", 64'(product), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R7: no done without start
        repeat (4) begin
            @(negedge clk);
            check("R7 idle done", 64'(done), 64'(0));
        end

        // R4: corners
        op_check("R4 minneg squared", VMIN, VMIN);
        check("R4 minneg value", 64'(product), 64'((2 * W)'(1) << (2 * W - 2)));
        op_check("R4 zero mult", VMIN, 0);
        op_check("R4 zero mcand", 0, VMAX);
        op_check("R4 minus one", VMIN, -1);
        op_check("R4 minus one b", 23, -1);
        op_check("R4 plus one", VMIN, 1);
        op_check("R4 plus one b", -17, 1);

        // R5: window patterns 010101, 101010, 011111, 100000
        for (int a = VMIN; a <= VMAX; a++) begin
            op_check("R5 pat 010101", a, 21);
            op_check("R5 pat 101010", a, -22);
            op_check("R6 pat 011111", a, VMAX);
            op_check("R6 pat 100000", a, VMIN);
        end

        // R3: start while busy is ignored
        @(negedge clk);
        start = 1'b1; mcand = W'(-27); mplier = W'(19);
        @(negedge clk);
        start = 1'b0;
        check("R3 busy after accept", 64'(busy), 64'(1));
        start = 1'b1; mcand = W'(31); mplier = W'(31);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R3 result kept", 64'(product), 64'(ref_mul(-27, 19)));
        check("R3 timing kept", 64'(lat), 64'(LAT));
        check("R3 busy low at done", 64'(busy), 64'(0));
        held = product;
        repeat (6) begin
            @(negedge clk);
            check("R3 no relaunch", 64'({busy, done}), 64'(0));
            check("R7 product hold", 64'(product), 64'(held));
        end

        // R1: exhaustive sweep
        for (int a = VMIN; a <= VMAX; a++) begin
            for (int x = VMIN; x <= VMAX; x++) begin
                run_op(a, x, got, lat);
                check("R1 product", 64'(got), 64'(ref_mul(a, x)));
                check("R2 latency", 64'(lat), 64'(LAT));
            end
        end

        @(negedge clk);
        check("R2 done one cycle", 64'(done), 64'(0));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule